// File: doc/BRIEF.md
# Banked Interrupt Group Register File

This block stores the group assignment of every interrupt line handled by an interrupt distributor and makes it visible through a byte-wide register window on a simple request bus. Each stored bit decides whether an interrupt belongs to the secure, higher-priority group (bit cleared) or to the non-secure, lower-priority group that is always signalled as a normal interrupt (bit set). The flattened per-CPU group vectors go straight to the prioritisation logic that sits downstream.

Interrupts 0 to 31 are private to each CPU. Every CPU has its own copy of their group bits, and a request reaches only the copy that belongs to the requesting CPU. Interrupts from 32 upward share one bit across all CPUs. Two configuration inputs decide whether grouping exists at all. The first marks the controller as the second revision. The second marks the security extensions as present. A request that the configuration does not permit reads as zero, and its write has no effect. A permitted request to a byte beyond the configured number of interrupts raises an error flag.

Top module: `grp_bank_regfile`

## Requirements
- R1: After reset every group bit of every CPU is 0, `rd_data` is 0 and `bus_err` is 0.
- R2: The window covers offsets 0x80 to 0x9F. In the byte at offset 0x80+n, bit i is the group of interrupt 8n+i. Bit k of the CPU c slice of `grp_vec` (bit position c*NUM_IRQ+k) is the group of interrupt k as seen by CPU c. A value of 1 means the non-secure group.
- R3: A permitted write to a valid byte replaces all eight covered group bits with `bus_wdata`, at the clock edge where `bus_wr` is sampled.
- R4: Read data is registered. It appears one cycle after `bus_rd` is sampled, and `rd_data` is 0 in any cycle that does not follow a permitted read of a valid byte. A read in the same cycle as a write returns the value from before the write.
- R5: When both `cfg_rev2` and `cfg_sec_ext` are 0, the whole window reads as zero, ignores writes and raises no error.
- R6: When `cfg_sec_ext` is 1, a request with `bus_secure` at 0 reads as zero, ignores writes and raises no error.
- R7: Group bits of interrupts 0 to 31 are banked per CPU. A read or write reaches only the copy of the CPU named by `bus_cpu`.
- R8: Group bits of interrupts 32 and above are shared. A write from any CPU index changes them in every CPU's slice of `grp_vec`.
- R9: A permitted request (read or write) whose first covered interrupt 8n is at or above NUM_IRQ sets `bus_err` for exactly the following cycle, returns zero data and changes no state.
- R10: Requests to offsets outside 0x80 to 0x9F are ignored: zero read data, no error, no state change.
- R11: A `bus_cpu` value at or above NUM_CPU reads zero from the private bytes and its private writes are ignored. Its shared-byte accesses behave normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rev2 | input | 1 | Controller is the revision that always supports grouping |
| cfg_sec_ext | input | 1 | Security extensions present |
| bus_addr | input | ADDR_W | Byte offset within the distributor |
| bus_wdata | input | 8 | Write byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_secure | input | 1 | Request carries the secure attribute |
| bus_cpu | input | 3 | Index of the requesting CPU |
| rd_data | output | 8 | Registered read byte |
| bus_err | output | 1 | Invalid register access, one cycle after the strobe |
| grp_vec | output | NUM_CPU*NUM_IRQ | Group bits per CPU, CPU c at c*NUM_IRQ |

## Verification
Every cycle, the assertions check several properties. Read data and errors occur only after a matching strobe, and an error never carries data. Writes that are denied, that miss the window or that point past NUM_IRQ leave the group vectors unchanged. A write never changes the private bits of any CPU except the one that made it, and the shared bits are identical in every CPU slice. Only the bench scenarios can show the data path itself: the byte-to-interrupt mapping, the replacement of all eight bits, the same-cycle read-before-write order, the out-of-range CPU index and the exact access rules for each configuration. The bench compares each of these against its behavioural model on every clock.

// File: rtl/grp_pkg.sv
package grp_pkg;
   localparam int PRIV_IRQS  = 32;
   localparam int PRIV_BYTES = PRIV_IRQS / 8;
   localparam int WIN_BASE   = 32'h80;
   localparam int WIN_BYTES  = 32;
   localparam int WIN_LSB    = $clog2(WIN_BYTES);
   localparam int CPU_IDX_W  = 3;
   localparam int MAX_CPU    = 1 << CPU_IDX_W;
   localparam int MAX_IRQ    = WIN_BYTES * 8;

   typedef struct packed {
      logic       hit;      // offset lies in the group window
      logic       permit;   // configuration and security allow the access
      logic       invalid;  // byte starts at or past the configured interrupt count
      logic       priv;     // byte covers banked private interrupts
      logic       cpu_ok;   // requesting CPU index exists
      logic [4:0] byte_idx; // byte number inside the window
   } grp_acc_t;

   function automatic int first_irq(input logic [4:0] b);
      return int'(b) * 8;
   endfunction
endpackage

// File: rtl/grp_access_decode.sv
module grp_access_decode
   import grp_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int NUM_CPU = 8,
   parameter int NUM_IRQ = 256
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 secure,
   input  logic [CPU_IDX_W-1:0] cpu,
   input  logic                 cfg_rev2,
   input  logic                 cfg_sec_ext,
   output grp_acc_t             acc
);
   localparam int TAG_W = ADDR_W - WIN_LSB;
   localparam logic [TAG_W-1:0] WIN_TAG = TAG_W'(WIN_BASE >> WIN_LSB);

   logic groups_on;
   logic ns_blocked;
   logic cpu_in_range;

   generate
      if (NUM_CPU >= MAX_CPU) begin : g_cpu_full
         assign cpu_in_range = 1'b1;
      end else begin : g_cpu_part
         assign cpu_in_range = (int'(cpu) < NUM_CPU);
      end
   endgenerate

   assign groups_on  = cfg_rev2 | cfg_sec_ext;
   assign ns_blocked = cfg_sec_ext & ~secure;

   always_comb begin
      acc          = '0;
      acc.hit      = (addr[ADDR_W-1:WIN_LSB] == WIN_TAG);
      acc.byte_idx = addr[WIN_LSB-1:0];
      acc.permit   = groups_on & ~ns_blocked;
      acc.invalid  = (first_irq(addr[WIN_LSB-1:0]) >= NUM_IRQ);
      acc.priv     = (first_irq(addr[WIN_LSB-1:0]) < PRIV_IRQS);
      acc.cpu_ok   = cpu_in_range;
   end
endmodule

// File: rtl/grp_priv_bank.sv
module grp_priv_bank
   import grp_pkg::*;
#(
   parameter int NUM_CPU = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [CPU_IDX_W-1:0]         cpu,
   input  logic [1:0]                   sel,
   input  logic [7:0]                   wdata,
   output logic [7:0]                   rdata,
   output logic [NUM_CPU*PRIV_IRQS-1:0] bits
);
   localparam int SEL_W = $clog2(PRIV_BYTES);

   generate
      for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
         logic [PRIV_IRQS-1:0] bank_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bank_q <= '0;
            end else if (we && cpu == CPU_IDX_W'(c)) begin
               bank_q[{sel[SEL_W-1:0], 3'b000} +: 8] <= wdata;
            end
         end
         assign bits[c*PRIV_IRQS +: PRIV_IRQS] = bank_q;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int c = 0; c < NUM_CPU; c++) begin
         if (cpu == CPU_IDX_W'(c)) begin
            rdata = bits[c*PRIV_IRQS + int'({sel, 3'b000}) +: 8];
         end
      end
   end
endmodule

// File: rtl/grp_shared_bank.sv
module grp_shared_bank
   import grp_pkg::*;
#(
   parameter int NUM_IRQ = 256
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [4:0]                     byte_idx,
   input  logic [7:0]                     wdata,
   output logic [7:0]                     rdata,
   output logic [NUM_IRQ-PRIV_IRQS-1:0]   bits
);
   localparam int SH_IRQS  = NUM_IRQ - PRIV_IRQS;
   localparam int SH_BYTES = SH_IRQS / 8;

   generate
      for (genvar b = 0; b < SH_BYTES; b++) begin : g_byte
         logic [7:0] byte_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               byte_q <= '0;
            end else if (we && byte_idx == 5'(b + PRIV_BYTES)) begin
               byte_q <= wdata;
            end
         end
         assign bits[b*8 +: 8] = byte_q;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int b = 0; b < SH_BYTES; b++) begin
         if (byte_idx == 5'(b + PRIV_BYTES)) begin
            rdata = bits[b*8 +: 8];
         end
      end
   end
endmodule

// File: rtl/grp_bank_regfile.sv
module grp_bank_regfile
   import grp_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int NUM_CPU = 8,
   parameter int NUM_IRQ = 256
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_rev2,
   input  logic                       cfg_sec_ext,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [7:0]                 bus_wdata,
   input  logic                       bus_wr,
   input  logic                       bus_rd,
   input  logic                       bus_secure,
   input  logic [CPU_IDX_W-1:0]       bus_cpu,
   output logic [7:0]                 rd_data,
   output logic                       bus_err,
   output logic [NUM_CPU*NUM_IRQ-1:0] grp_vec
);
   localparam int SH_IRQS = NUM_IRQ - PRIV_IRQS;

   generate
      if (NUM_CPU < 1 || NUM_CPU > MAX_CPU) begin : g_bad_cpu
         $error("grp_bank_regfile: NUM_CPU must lie in 1..8");
      end
      if (NUM_IRQ < PRIV_IRQS || NUM_IRQ > MAX_IRQ || (NUM_IRQ % PRIV_IRQS) != 0) begin : g_bad_irq
         $error("grp_bank_regfile: NUM_IRQ must be a multiple of 32 in 32..256");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("grp_bank_regfile: ADDR_W must be at least 8");
      end
   endgenerate

   grp_acc_t acc;
   logic     acc_ok;
   logic     do_wr;
   logic     priv_we;
   logic     sh_we;
   logic [7:0] priv_rd;
   logic [7:0] sh_rd;
   logic [7:0] rd_byte;
   logic [NUM_CPU*PRIV_IRQS-1:0] priv_bits;

   grp_access_decode #(
      .ADDR_W (ADDR_W),
      .NUM_CPU(NUM_CPU),
      .NUM_IRQ(NUM_IRQ)
   ) u_dec (
      .addr       (bus_addr),
      .secure     (bus_secure),
      .cpu        (bus_cpu),
      .cfg_rev2   (cfg_rev2),
      .cfg_sec_ext(cfg_sec_ext),
      .acc        (acc)
   );

   assign acc_ok  = acc.hit & acc.permit & ~acc.invalid;
   assign do_wr   = bus_wr & acc_ok;
   assign priv_we = do_wr & acc.priv & acc.cpu_ok;
   assign sh_we   = do_wr & ~acc.priv;

   grp_priv_bank #(
      .NUM_CPU(NUM_CPU)
   ) u_priv (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (priv_we),
      .cpu  (bus_cpu),
      .sel  (acc.byte_idx[1:0]),
      .wdata(bus_wdata),
      .rdata(priv_rd),
      .bits (priv_bits)
   );

   generate
      if (SH_IRQS > 0) begin : g_shared
         logic [SH_IRQS-1:0] sh_bits;
         grp_shared_bank #(
            .NUM_IRQ(NUM_IRQ)
         ) u_sh (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (sh_we),
            .byte_idx(acc.byte_idx),
            .wdata   (bus_wdata),
            .rdata   (sh_rd),
            .bits    (sh_bits)
         );
         for (genvar c = 0; c < NUM_CPU; c++) begin : g_merge
            assign grp_vec[c*NUM_IRQ +: PRIV_IRQS]           = priv_bits[c*PRIV_IRQS +: PRIV_IRQS];
            assign grp_vec[c*NUM_IRQ + PRIV_IRQS +: SH_IRQS] = sh_bits;
         end
      end else begin : g_priv_only
         logic unused_sh_we;
         assign unused_sh_we = sh_we;
         assign sh_rd        = '0;
         assign grp_vec      = priv_bits;
      end
   endgenerate

   assign rd_byte = acc.priv ? (acc.cpu_ok ? priv_rd : 8'h00) : sh_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         bus_err <= 1'b0;
      end else begin
         rd_data <= (bus_rd && acc_ok) ? rd_byte : 8'h00;
         bus_err <= (bus_rd | bus_wr) & acc.hit & acc.permit & acc.invalid;
      end
   end
endmodule

// File: rtl/grp_bank_chk.sv
module grp_bank_chk
   import grp_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int NUM_CPU = 8,
   parameter int NUM_IRQ = 256
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cfg_rev2,
   input logic                       cfg_sec_ext,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic [7:0]                 bus_wdata,
   input logic                       bus_wr,
   input logic                       bus_rd,
   input logic                       bus_secure,
   input logic [CPU_IDX_W-1:0]       bus_cpu,
   input logic [7:0]                 rd_data,
   input logic                       bus_err,
   input logic [NUM_CPU*NUM_IRQ-1:0] grp_vec
);
   localparam int SH_IRQS = NUM_IRQ - PRIV_IRQS;

   logic chk_in_win;
   logic chk_allowed;
   logic chk_past_end;
   logic [7:0] unused_wdata;

   assign unused_wdata = bus_wdata;
   assign chk_in_win   = (int'(bus_addr) >= WIN_BASE) && (int'(bus_addr) < WIN_BASE + WIN_BYTES);
   assign chk_allowed  = (cfg_rev2 || cfg_sec_ext) && !(cfg_sec_ext && !bus_secure);
   assign chk_past_end = (int'(bus_addr) - WIN_BASE) * 8 >= NUM_IRQ;

   // R4
   rd_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data != 8'h00) |-> $past(bus_rd));

   // R9
   err_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(bus_rd || bus_wr));

   // R9
   err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (rd_data == 8'h00));

   // R5 R6
   denied_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !chk_allowed) |=> $stable(grp_vec));

   // R9
   past_end_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && chk_in_win && chk_past_end) |=> $stable(grp_vec));

   // R10
   miss_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !chk_in_win) |=> $stable(grp_vec));

   generate
      for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
         // R7
         other_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_cpu != CPU_IDX_W'(c)) |=> $stable(grp_vec[c*NUM_IRQ +: PRIV_IRQS]));
         if (SH_IRQS > 0 && c > 0) begin : g_common
            // R8
            shared_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
               grp_vec[c*NUM_IRQ + PRIV_IRQS +: SH_IRQS] == grp_vec[PRIV_IRQS +: SH_IRQS]);
         end
      end
   endgenerate
endmodule

bind grp_bank_regfile grp_bank_chk #(
   .ADDR_W (ADDR_W),
   .NUM_CPU(NUM_CPU),
   .NUM_IRQ(NUM_IRQ)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_rev2   (cfg_rev2),
   .cfg_sec_ext(cfg_sec_ext),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_secure (bus_secure),
   .bus_cpu    (bus_cpu),
   .rd_data    (rd_data),
   .bus_err    (bus_err),
   .grp_vec    (grp_vec)
);

// File: tb/sim_grp_bank_regfile.sv
`timescale 1ns/1ps
module sim_grp_bank_regfile;
   localparam int ADDR_W = 12;
   localparam int NCPU   = 4;
   localparam int NIRQ   = 96;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_rev2 = 1'b0;
   logic cfg_sec_ext = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic bus_wr = 1'b0;
   logic bus_rd = 1'b0;
   logic bus_secure = 1'b0;
   logic [2:0] bus_cpu = '0;
   logic [7:0] rd_data;
   logic bus_err;
   logic [NCPU*NIRQ-1:0] grp_vec;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   bit ref_priv [0:7][0:31];
   bit ref_sh   [0:255];

   always #2 clk = ~clk;

   grp_bank_regfile #(.ADDR_W(ADDR_W), .NUM_CPU(NCPU), .NUM_IRQ(NIRQ)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_rev2(cfg_rev2), .cfg_sec_ext(cfg_sec_ext),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_secure(bus_secure), .bus_cpu(bus_cpu), .rd_data(rd_data),
      .bus_err(bus_err), .grp_vec(grp_vec)
   );

   function automatic bit model_bit(input int cpu, input int irq);
      if (irq < 32) return (cpu < NCPU) ? ref_priv[cpu][irq] : 1'b0;
      return ref_sh[irq];
   endfunction

   function automatic logic [NCPU*NIRQ-1:0] model_vec();
      logic [NCPU*NIRQ-1:0] v;
      for (int c = 0; c < NCPU; c++)
         for (int k = 0; k < NIRQ; k++)
            v[c*NIRQ + k] = model_bit(c, k);
      return v;
   endfunction

   task automatic compare(input string tag, input logic [7:0] exp_rd, input bit exp_err);
      logic [NCPU*NIRQ-1:0] ev;
      ev = model_vec();
      checks += 3;
      if (rd_data !== exp_rd) begin
         errors++;
         $display("FAIL %s rd_data actual %h expected %h", tag, rd_data, exp_rd);
      end
      if (bus_err !== exp_err) begin
         errors++;
         $display("FAIL %s bus_err actual %b expected %b", tag, bus_err, exp_err);
      end
      if (grp_vec !== ev) begin
         errors++;
         $display("FAIL %s grp_vec actual %h expected %h", tag, grp_vec, ev);
      end
   endtask

   // one bus cycle: drive at a falling edge, compare at the next falling edge
   task automatic op(input int a, input int wd, input bit wr, input bit rd,
                     input bit sec, input int cpu, input string tag);
      bit hit, allowed, past_end, ok;
      int first;
      logic [7:0] exp_rd;
      bit exp_err;
      bus_addr   = ADDR_W'(a);
      bus_wdata  = 8'(wd);
      bus_wr     = wr;
      bus_rd     = rd;
      bus_secure = sec;
      bus_cpu    = 3'(cpu);
      hit      = (a >= 'h80) && (a < 'hA0);
      first    = (a - 'h80) * 8;
      allowed  = (cfg_rev2 || cfg_sec_ext) && !(cfg_sec_ext && !sec);
      past_end = first >= NIRQ;
      ok       = hit && allowed && !past_end;
      exp_rd   = 8'h00;
      if (rd && ok)
         for (int i = 0; i < 8; i++) exp_rd[i] = model_bit(cpu, first + i);
      exp_err = (rd || wr) && hit && allowed && past_end;
      if (wr && ok)
         for (int i = 0; i < 8; i++) begin
            if (first + i < 32) begin
               if (cpu < NCPU) ref_priv[cpu][first + i] = wd[i];
            end else begin
               ref_sh[first + i] = wd[i];
            end
         end
      @(negedge clk);
      compare(tag, exp_rd, exp_err);
   endtask

   task automatic idle(input string tag);
      op(0, 0, 1'b0, 1'b0, 1'b0, 0, tag);
   endtask

   initial begin
      int limit = 100000;
      for (int n = 0; n < limit; n++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      foreach (ref_priv[c, k]) ref_priv[c][k] = 1'b0;
      foreach (ref_sh[k]) ref_sh[k] = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      compare("R1 reset", 8'h00, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after release", 8'h00, 1'b0);

      cfg_rev2 = 1'b1;
      // R2 R8: shared byte written by CPU 0, read by CPU 2
      op('h84, 'hA5, 1, 0, 1, 0, "R2 shared write");
      op('h84, 0, 0, 1, 1, 2, "R8 shared read other cpu");
      op('h8B, 'h3C, 1, 0, 0, 3, "R2 last valid byte");
      op('h8B, 0, 0, 1, 0, 1, "R2 last valid read");
      // R3: full byte replacement, read during write returns old value (R4)
      op('h84, 'h5A, 1, 1, 1, 1, "R4 read before write");
      op('h84, 0, 0, 1, 1, 0, "R3 byte replaced");
      idle("R4 idle zero");
      // R7: private banking
      op('h80, 'hF0, 1, 0, 1, 1, "R7 cpu1 write");
      op('h80, 0, 0, 1, 1, 0, "R7 cpu0 own copy");
      op('h80, 0, 0, 1, 1, 1, "R7 cpu1 own copy");
      op('h83, 'h81, 1, 0, 1, 3, "R7 cpu3 write");
      op('h83, 0, 0, 1, 1, 3, "R7 cpu3 read");
      // R11: CPU index beyond NCPU
      op('h81, 'hFF, 1, 0, 1, 5, "R11 priv write ignored");
      op('h81, 0, 0, 1, 1, 5, "R11 priv read zero");
      op('h88, 'h77, 1, 0, 1, 6, "R11 shared write works");
      op('h88, 0, 0, 1, 1, 0, "R11 shared visible");
      // R9: past the configured interrupt count
      op('h8C, 'hFF, 1, 0, 1, 0, "R9 write past end");
      idle("R9 error one cycle");
      op('h9F, 0, 0, 1, 1, 2, "R9 read past end");
      // R10: outside the window
      op('h7F, 'hFF, 1, 0, 1, 0, "R10 below window");
      op('hA0, 'hFF, 1, 1, 1, 0, "R10 above window");
      // R5: no grouping configured
      cfg_rev2 = 1'b0;
      op('h84, 'hFF, 1, 0, 1, 0, "R5 write ignored");
      op('h84, 0, 0, 1, 1, 0, "R5 read zero");
      op('h8C, 0, 0, 1, 1, 0, "R5 no error");
      // R6: security extensions, non-secure requests
      cfg_sec_ext = 1'b1;
      op('h85, 'hFF, 1, 0, 0, 0, "R6 ns write ignored");
      op('h84, 0, 0, 1, 0, 0, "R6 ns read zero");
      op('h8C, 0, 0, 1, 0, 0, "R6 ns no error");
      op('h85, 'hC3, 1, 0, 1, 2, "R6 secure write");
      op('h85, 0, 0, 1, 1, 0, "R6 secure read");
      // mixed traffic against the model
      for (int n = 0; n < 400; n++) begin
         if (n % 50 == 0) begin
            cfg_rev2    = 1'($urandom_range(0, 1));
            cfg_sec_ext = 1'($urandom_range(0, 1));
         end
         op(int'($urandom_range('h7C, 'hA3)), int'($urandom_range(0, 255)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), int'($urandom_range(0, 7)), "R2 R3 R7 R8 mixed");
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule